// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit sits between a processor and a 4 MB RAM. It turns each 24-bit virtual address into a 22-bit physical address. Pages are 32 KB, so the low 15 address bits pass through unchanged. The virtual page number above those bits selects one of 128 page-table entries. Each entry supplies a 7-bit frame number together with its protection fields.

A cycle raises `bus_err` when it cannot be translated: the page number lies beyond the table, the entry is invalid, the entry belongs to another process, or the cycle writes to a page that is not writable. The processor uses this as its bus-error input and traps to the operating system. The operating system then fixes the table and restarts the cycle.

The table and a small control register are written through a register port. Writes are accepted only while the processor is running a supervisor data cycle. The control register holds the current process tag and a bypass bit. While the bypass bit is set, supervisor cycles reach RAM directly with no translation and no checks. This lets the system software load pages and tables in physical memory.

Top module: `page_xlate_unit`

## Requirements
- R1: For every cycle, `phys_addr[14:0]` equals `cyc_va[14:0]`.
- R2: A page is in range when `cyc_va[23:22]` is 0. An in-range page uses entry `cyc_va[21:15]`. If that entry is valid and its process tag equals the current process tag, then `phys_addr[21:15]` is the entry's frame and `bus_err` stays low for reads.
- R3: If the selected entry is invalid, or its tag differs from the current tag and the entry is not locked, a valid cycle raises `bus_err` in the same cycle.
- R4: A valid cycle with `cyc_va[23:22]` nonzero raises `bus_err`, unless bypass applies (R7).
- R5: A write cycle that hits an entry whose write-enable field is 0 raises `bus_err`. A read cycle to the same entry completes without error.
- R6: A locked entry that is valid translates for any current process tag.
- R7: The function code is `cyc_fc`: 00 user data, 01 user program, 10 supervisor data, 11 supervisor program. When the bypass bit is set and `cyc_fc[1]` is 1, `phys_addr` equals `cyc_va[21:0]` and `bus_err` stays low. User cycles are still translated and checked.
- R8: Register writes take effect at the clock edge, and only when `reg_wr` is 1 and `cyc_fc` is 10. Any other function code leaves the table and the control register unchanged.
  - With `reg_sel`=0, entry `reg_idx` is loaded from `reg_data`: bits [6:0] frame, bit 7 write-enable, bit 8 lock, bit 9 valid, bits [13:10] process tag.
  - With `reg_sel`=1, the control register is loaded: bits [3:0] current process tag, bit 4 bypass.
- R9: After reset all entries are invalid, the current tag is 0 and bypass is off.
- R10: `bus_err` is low whenever `cyc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | A processor memory cycle is in progress |
| cyc_fc | input | 2 | Function code of the current cycle |
| cyc_write | input | 1 | Current cycle is a write |
| cyc_va | input | 24 | Virtual address |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 1 | 0: page-table entry, 1: control register |
| reg_idx | input | 7 | Entry index for table writes |
| reg_data | input | 16 | Register write data |
| phys_addr | output | 22 | Physical address to RAM |
| bus_err | output | 1 | Translation or protection fault |

## Verification
The assertions check four things on every cycle:
- the offset pass-through;
- a quiet `bus_err` when no cycle is running;
- the out-of-range fault, the read-only write fault and the clean bypass;
- that rejected register writes leave every entry and the control register unchanged.

Only the bench's scenarios can show that a frame number loaded through the port appears on later cycles. The same holds for tag matching across context switches, for locked pages surviving a tag change, and for reset leaving every page unmapped. The bench checks these against its own model of the table.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int VA_W    = 24;
  localparam int PA_W    = 22;
  localparam int OFS_W   = 15;
  localparam int ENTRIES = 128;
  localparam int PID_W   = 4;
  localparam int RDATA_W = 16;
  localparam int FRAME_W = PA_W - OFS_W;
  localparam int VPN_W   = VA_W - OFS_W;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int PTE_W   = PID_W + 3 + FRAME_W;

  typedef enum logic [1:0] {
    FC_USR_DATA = 2'b00,
    FC_USR_PROG = 2'b01,
    FC_SUP_DATA = 2'b10,
    FC_SUP_PROG = 2'b11
  } fc_t;

  // packed MSB first: tag, valid, lock, write-enable, frame
  typedef struct packed {
    logic [PID_W-1:0]   pid;
    logic               valid;
    logic               lock;
    logic               wen;
    logic [FRAME_W-1:0] frame;
  } pte_t;

  function automatic pte_t unpack_pte(input logic [RDATA_W-1:0] d);
    return d[PTE_W-1:0];
  endfunction

  function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFS_W];
  endfunction

  function automatic logic vpn_in_table(input logic [VPN_W-1:0] vpn);
    return {1'b0, vpn} < (VPN_W+1)'(ENTRIES);
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [FRAME_W-1:0] frame,
                                              input logic [VA_W-1:0] va);
    return {frame, va[OFS_W-1:0]};
  endfunction

  function automatic logic is_super(input fc_t fc);
    return (fc == FC_SUP_DATA) || (fc == FC_SUP_PROG);
  endfunction

  function automatic logic cfg_write_ok(input logic wr, input fc_t fc);
    return wr && (fc == FC_SUP_DATA);
  endfunction
endpackage

// File: rtl/pxu_ctrl.sv
module pxu_ctrl
  import pxu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RDATA_W-1:0] wr_data,
  output logic [PID_W-1:0]   cur_pid,
  output logic               bypass_en
);
  logic unused_hi;
  assign unused_hi = ^wr_data[RDATA_W-1:PID_W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_pid   <= '0;
      bypass_en <= 1'b0;
    end else if (wr_en) begin
      cur_pid   <= wr_data[PID_W-1:0];
      bypass_en <= wr_data[PID_W];
    end
  end
endmodule

// File: rtl/pxu_table.sv
module pxu_table
  import pxu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [RDATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output pte_t               rd_pte
);
  pte_t               ent_q [ENTRIES];
  logic [ENTRIES-1:0] ent_we;
  pte_t               wr_pte;
  logic               unused_hi;

  assign wr_pte    = unpack_pte(wr_data);
  assign unused_hi = ^wr_data[RDATA_W-1:PTE_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign ent_we[i] = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[i] <= '0;
      else if (ent_we[i]) ent_q[i] <= wr_pte;
    end

    // R8
    ent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_we[i] |=> $stable(ent_q[i]));
  end

  assign rd_pte = ent_q[rd_idx];
endmodule

// File: rtl/pxu_lookup.sv
module pxu_lookup
  import pxu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_valid,
  input  fc_t              cyc_fc,
  input  logic             cyc_write,
  input  logic [VA_W-1:0]  cyc_va,
  input  pte_t             pte,
  input  logic [PID_W-1:0] cur_pid,
  input  logic             bypass_en,
  output logic [PA_W-1:0]  phys_addr,
  output logic             bus_err
);
  logic [VPN_W-1:0] vpn;
  logic super_c, bypass_act, in_range, tag_ok, hit_ev, miss_ev, prot_ev;

  assign vpn        = vpn_of(cyc_va);
  assign super_c    = is_super(cyc_fc);
  assign bypass_act = bypass_en && super_c;
  assign in_range   = vpn_in_table(vpn);
  assign tag_ok     = pte.lock || (pte.pid == cur_pid);
  assign hit_ev     = in_range && pte.valid && tag_ok;
  assign miss_ev    = !bypass_act && !hit_ev;
  assign prot_ev    = !bypass_act && hit_ev && cyc_write && !pte.wen;

  assign bus_err   = cyc_valid && (miss_ev || prot_ev);
  assign phys_addr = bypass_act ? cyc_va[PA_W-1:0] : join_pa(pte.frame, cyc_va);

  // R7
  bypass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && bypass_en && super_c) |->
      (!bus_err && phys_addr == cyc_va[PA_W-1:0]));

  // R5
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !bypass_act && in_range && pte.valid && tag_ok &&
     cyc_write && !pte.wen) |-> bus_err);

  // R4
  range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !bypass_act && !in_range) |-> bus_err);
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pxu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_valid,
  input  logic [1:0]         cyc_fc,
  input  logic               cyc_write,
  input  logic [VA_W-1:0]    cyc_va,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [IDX_W-1:0]   reg_idx,
  input  logic [RDATA_W-1:0] reg_data,
  output logic [PA_W-1:0]    phys_addr,
  output logic               bus_err
);
  fc_t              fc;
  logic             cfg_ok, tbl_wr, ctl_wr;
  logic [PID_W-1:0] cur_pid;
  logic             bypass_en;
  logic [VPN_W-1:0] vpn;
  pte_t             sel_pte;

  assign fc     = fc_t'(cyc_fc);
  assign cfg_ok = cfg_write_ok(reg_wr, fc);
  assign tbl_wr = cfg_ok && !reg_sel;
  assign ctl_wr = cfg_ok && reg_sel;
  assign vpn    = vpn_of(cyc_va);

  pxu_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_data(reg_data),
    .cur_pid(cur_pid), .bypass_en(bypass_en)
  );

  pxu_table i_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .wr_idx(reg_idx),
    .wr_data(reg_data), .rd_idx(vpn[IDX_W-1:0]), .rd_pte(sel_pte)
  );

  pxu_lookup i_lookup (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_fc(fc),
    .cyc_write(cyc_write), .cyc_va(cyc_va), .pte(sel_pte),
    .cur_pid(cur_pid), .bypass_en(bypass_en),
    .phys_addr(phys_addr), .bus_err(bus_err)
  );

  // R1
  ofs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> phys_addr[OFS_W-1:0] == cyc_va[OFS_W-1:0]);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> !bus_err);

  // R8
  ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && fc != FC_SUP_DATA) |=> ($stable(cur_pid) && $stable(bypass_en)));
endmodule

// File: tb/test_page_xlate_unit.sv
module test_page_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [1:0]  cyc_fc = 2'b00;
  logic        cyc_write = 1'b0;
  logic [23:0] cyc_va = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [6:0]  reg_idx = '0;
  logic [15:0] reg_data = '0;
  logic [21:0] phys_addr;
  logic        bus_err;

  int errors = 0;
  int checks = 0;

  logic [13:0] m_tbl [128];
  logic [3:0]  m_pid = 4'd0;
  logic        m_byp = 1'b0;

  always #10 clk = ~clk;

  page_xlate_unit i_page_xlate_unit (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_fc(cyc_fc),
    .cyc_write(cyc_write), .cyc_va(cyc_va), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_idx(reg_idx), .reg_data(reg_data), .phys_addr(phys_addr), .bus_err(bus_err)
  );

  function automatic logic [15:0] mk_pte(input logic [3:0] pid, input logic v,
                                         input logic lk, input logic we,
                                         input logic [6:0] fr);
    return {2'b00, pid, v, lk, we, fr};
  endfunction

  // Model of the outcome, written from the requirements.
  function automatic void model(input logic [23:0] va, input logic [1:0] fc,
                                input logic wr, output logic err,
                                output logic [21:0] pa, output string req);
    logic [13:0] e;
    err = 1'b0;
    pa  = va[21:0];
    req = "R2";
    if (fc[1] && m_byp) begin
      req = "R7";
      return;
    end
    if (va[23:22] != 2'b00) begin
      err = 1'b1;
      req = "R4";
      return;
    end
    e  = m_tbl[va[21:15]];
    pa = {e[6:0], va[14:0]};
    if (!e[9]) begin
      err = 1'b1;
      req = "R3";
    end else if (!e[8] && e[13:10] != m_pid) begin
      err = 1'b1;
      req = "R3";
    end else begin
      if (e[8]) req = "R6";
      if (wr && !e[7]) begin
        err = 1'b1;
        req = "R5";
      end
    end
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [6:0] idx,
                           input logic [15:0] data, input logic [1:0] fc);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_idx = idx; reg_data = data; cyc_fc = fc;
    @(negedge clk);
    reg_wr = 1'b0;
    if (fc == 2'b10) begin
      if (sel) begin
        m_pid = data[3:0];
        m_byp = data[4];
      end else begin
        m_tbl[idx] = data[13:0];
      end
    end
  endtask

  task automatic access(input logic [23:0] va, input logic [1:0] fc,
                        input logic wr, input string tag);
    logic        e_err;
    logic [21:0] e_pa;
    string       req;
    @(negedge clk);
    cyc_valid = 1'b1; cyc_va = va; cyc_fc = fc; cyc_write = wr;
    #2;
    model(va, fc, wr, e_err, e_pa, req);
    if (tag != "") req = tag;
    check(bus_err == e_err, req, "bus_err", 32'(bus_err), 32'(e_err));
    check(phys_addr[14:0] == va[14:0], "R1", "offset", 32'(phys_addr), 32'(va[14:0]));
    if (!e_err)
      check(phys_addr == e_pa, req, "phys_addr", 32'(phys_addr), 32'(e_pa));
    cyc_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 128; i++) m_tbl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9: after reset every page faults, bypass is off, tag is 0
    access(24'h000123, 2'b00, 1'b0, "R9");
    access(24'h1F8001, 2'b10, 1'b0, "R9");

    cfg_write(1'b1, 7'd0, 16'h0003, 2'b10);
    cfg_write(1'b0, 7'd5, mk_pte(4'd3, 1, 0, 1, 7'h2A), 2'b10);
    cfg_write(1'b0, 7'd6, mk_pte(4'd3, 1, 0, 0, 7'h11), 2'b10);
    cfg_write(1'b0, 7'd7, mk_pte(4'd2, 1, 0, 1, 7'h33), 2'b10);
    cfg_write(1'b0, 7'd8, mk_pte(4'd2, 1, 1, 1, 7'h7F), 2'b10);
    access({2'b00, 7'd5, 15'h1234}, 2'b00, 1'b0, "R2");
    access({2'b00, 7'd5, 15'h7FFF}, 2'b00, 1'b1, "R2");
    access({2'b00, 7'd6, 15'h0042}, 2'b01, 1'b0, "R5");
    access({2'b00, 7'd6, 15'h0042}, 2'b00, 1'b1, "R5");
    access({2'b00, 7'd7, 15'h0001}, 2'b00, 1'b0, "R3");
    access({2'b00, 7'd9, 15'h0001}, 2'b00, 1'b0, "R3");
    access({2'b00, 7'd8, 15'h5555}, 2'b00, 1'b0, "R6");
    access({2'b10, 7'd5, 15'h1234}, 2'b00, 1'b0, "R4");
    access({2'b01, 7'd5, 15'h1234}, 2'b10, 1'b0, "R4");

    // R8: writes with any function code other than supervisor data are ignored
    cfg_write(1'b0, 7'd5, 16'h0000, 2'b00);
    cfg_write(1'b0, 7'd5, 16'h0000, 2'b11);
    cfg_write(1'b1, 7'd0, 16'h0017, 2'b01);
    access({2'b00, 7'd5, 15'h0ABC}, 2'b00, 1'b0, "R8");
    access({2'b10, 7'd0, 15'h0ABC}, 2'b11, 1'b0, "R8");

    // R6: a context switch keeps locked pages reachable
    cfg_write(1'b1, 7'd0, 16'h0009, 2'b10);
    access({2'b00, 7'd8, 15'h0777}, 2'b01, 1'b0, "R6");
    access({2'b00, 7'd5, 15'h0777}, 2'b00, 1'b0, "R3");

    // R7: bypass for supervisor only
    cfg_write(1'b1, 7'd0, 16'h0013, 2'b10);
    access(24'hC12345, 2'b10, 1'b1, "R7");
    access(24'h3ABCDE, 2'b11, 1'b0, "R7");
    access(24'hC12345, 2'b00, 1'b0, "R4");
    access({2'b00, 7'd5, 15'h0001}, 2'b01, 1'b0, "R2");

    // R10: no cycle, no error
    @(negedge clk);
    cyc_valid = 1'b0; cyc_va = 24'hFFFFFF; cyc_fc = 2'b00; cyc_write = 1'b1;
    #2;
    check(bus_err == 1'b0, "R10", "bus_err idle", 32'(bus_err), 32'd0);

    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [23:0] va;
      r = $urandom % 8;
      if (r == 0) begin
        if ($urandom % 6 == 0)
          cfg_write(1'b1, 7'($urandom), {11'($urandom), ($urandom % 5 == 0), 2'b00, 2'($urandom)}, 2'($urandom));
        else
          cfg_write(1'b0, 7'($urandom % 16),
                    mk_pte({2'b00, 2'($urandom)}, ($urandom % 4 != 0), ($urandom % 5 == 0),
                           1'($urandom), 7'($urandom)), 2'($urandom));
      end else begin
        va = {($urandom % 10 == 0) ? 2'($urandom) : 2'b00, 7'($urandom % 16), 15'($urandom)};
        access(va, 2'($urandom), 1'($urandom), "");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule